// File: doc/BRIEF.md
# Gated Sixteen-Way Clock Fan-Out

This block distributes one reference clock to sixteen clock outputs and one feedback output. Each of the sixteen outputs has an enable bit. A set bit lets the output follow the clock. A cleared bit holds the output low, and the output stays driven. The enable bits live in two configuration bytes. A third configuration byte carries a 2-bit code that selects the input-to-feedback delay. That code is passed out unchanged to a delay element outside this block.

A serial front-end, which is not part of this block, loads the configuration bytes through a simple byte-write port. Enable changes are taken into a falling-edge register, so a gated output can only start or stop between clock pulses. It never produces a truncated pulse.

A shared drive-enable pin switches all sixteen outputs to high impedance. The tri-state is modelled as a per-output drive-enable vector that sits next to the data outputs. The feedback output is never gated and never tri-stated, so the external timing loop stays closed.

Top module: `ckg_fanout`

## Requirements
- R1: Output n (0 to 7) is enabled by bit n of configuration byte index 1. Output n (8 to 15) is enabled by bit n-8 of configuration byte index 2.
- R2: An enabled output is high while the reference clock is high. Every output is low while the reference clock is low. A disabled output stays low in both clock phases.
- R3: A change of enable takes effect at the first falling clock edge after the write is captured. Outputs are therefore all low just before every rising edge, and the new value first shows in the clock-high phase that follows the next rising edge after capture.
- R4: While drv_en is 0, all sixteen bits of clk_oe are 0 (high impedance). While it is 1, all sixteen bits are 1. The change appears after the second rising edge that samples the new pin value. clk_oe never shows mixed bits.
- R5: fb_out equals ref_clk at all times, whatever the enables, drv_en or reset.
- R6: After reset, all sixteen enables are 1, dly_sel is 00 and clk_oe is all ones when drv_en is held high. Reset asserts asynchronously and releases on a rising edge.
- R7: A write to byte index 0 sets dly_sel to bits 1:0 of the written data from the next rising edge. Bits 7:2 of that byte are ignored.
- R8: A write to byte index 3 changes neither any enable nor dly_sel.
- R9: clk_oe does not depend on the enable bits, and the enable bits do not depend on drv_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Shared drive enable, 0 tri-states the sixteen outputs |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | 2 | Configuration byte index (0 delay, 1 low enables, 2 high enables) |
| cfg_data | input | 8 | Configuration byte value |
| clk_out | output | 16 | Gated clock outputs |
| clk_oe | output | 16 | Per-output drive enable |
| fb_out | output | 1 | Ungated feedback clock |
| dly_sel | output | 2 | Delay-select code for the external delay element |

## Verification
A byte written in the clock-high phase is captured at the next rising edge. The enable register takes it at the falling edge that follows. The gated result is sampled 1 ns into the clock-high phase after the next rising edge, and dly_sel is sampled at that same point.

A drv_en change is sampled one cycle after it is driven to confirm that the old value still holds. It is sampled again one cycle later, once the two synchroniser stages have passed it through.

Low-phase samples, taken 1 ns after each falling edge, confirm that every output is low and that fb_out follows the clock.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 2;
  localparam int DLY_W  = 2;
  typedef logic [BYTE_W-1:0] cfg_byte_t;
endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ckg_cfg_regs.sv
module ckg_cfg_regs
  import ckg_pkg::*;
#(
  parameter int N_OUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  cfg_byte_t        data,
  output logic [N_OUT-1:0] out_en,
  output logic [DLY_W-1:0] dly_code
);
  localparam int N_EN_BYTES = N_OUT / BYTE_W;

  // byte 0: only the delay code is stored
  logic             dly_ld;
  logic [DLY_W-1:0] dly_q;

  always_comb begin
    dly_ld = we && (idx == IDX_W'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= '0;
    else if (dly_ld) dly_q <= data[DLY_W-1:0];
  end

  assign dly_code = dly_q;

  // enable bytes at indices 1..N_EN_BYTES
  for (genvar b = 0; b < N_EN_BYTES; b++) begin : g_en_byte
    logic      ld;
    cfg_byte_t en_q;

    always_comb begin
      ld = we && (idx == IDX_W'(b + 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= '1;
      else if (ld) en_q <= data;
    end

    assign out_en[b*BYTE_W +: BYTE_W] = en_q;
  end
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic clk_o
);
  logic en_q;
  logic en_d;

  always_comb begin
    en_d = en;
  end

  // falling-edge capture: enable only moves while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  assign clk_o = clk & en_q;
endmodule

// File: rtl/ckg_fanout.sv
module ckg_fanout
  import ckg_pkg::*;
#(
  parameter int N_OUT       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             drv_en,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [BYTE_W-1:0] cfg_data,
  output logic [N_OUT-1:0] clk_out,
  output logic [N_OUT-1:0] clk_oe,
  output logic             fb_out,
  output logic [DLY_W-1:0] dly_sel
);
  logic             rst_q_n;
  logic             drv_en_s;
  logic [N_OUT-1:0] out_en;

  ckg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(rst_q_n)
  );

  // pin pull-up modelled by reset value 1
  ckg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_oe_sync (
    .clk(ref_clk), .rst_n(rst_q_n), .d(drv_en), .q(drv_en_s)
  );

  ckg_cfg_regs #(.N_OUT(N_OUT)) u_cfg (
    .clk(ref_clk), .rst_n(rst_q_n), .we(cfg_we), .idx(cfg_idx),
    .data(cfg_data), .out_en(out_en), .dly_code(dly_sel)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    ckg_gate u_gate (
      .clk(ref_clk), .rst_n(rst_q_n), .en(out_en[i]), .clk_o(clk_out[i])
    );
    assign clk_oe[i] = drv_en_s;
  end

  assign fb_out = ref_clk;
endmodule

// File: rtl/ckg_fanout_chk.sv
module ckg_fanout_chk #(
  parameter int N_OUT = 16
) (
  input logic             ref_clk,
  input logic             rst_q_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_idx,
  input logic [7:0]       cfg_data,
  input logic [N_OUT-1:0] clk_out,
  input logic [N_OUT-1:0] clk_oe,
  input logic             fb_out,
  input logic [1:0]       dly_sel
);
  // R3
  outputs_low_before_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_q_n)
    clk_out == '0);

  // R4
  oe_uniform_chk: assert property (@(posedge ref_clk) disable iff (!rst_q_n)
    (clk_oe == '0) || (clk_oe == '1));

  // R5
  fb_low_before_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_q_n)
    !fb_out);

  // R5
  fb_high_before_fall_chk: assert property (@(negedge ref_clk) disable iff (!rst_q_n)
    fb_out);

  // R7
  dly_load_chk: assert property (@(posedge ref_clk) disable iff (!rst_q_n)
    (cfg_we && cfg_idx == 2'd0) |=> (dly_sel == $past(cfg_data[1:0])));

  // R8
  idx3_ignored_chk: assert property (@(posedge ref_clk) disable iff (!rst_q_n)
    (cfg_we && cfg_idx == 2'd3) |=> $stable(dly_sel));
endmodule

bind ckg_fanout ckg_fanout_chk #(.N_OUT(N_OUT)) u_chk (
  .ref_clk(ref_clk), .rst_q_n(rst_q_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_data(cfg_data), .clk_out(clk_out), .clk_oe(clk_oe), .fb_out(fb_out),
  .dly_sel(dly_sel)
);

// File: tb/ckg_fanout_bench.sv
`timescale 1ns/1ps
module ckg_fanout_bench;
  logic        ref_clk = 1'b0;
  logic        rst_n;
  logic        drv_en;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [7:0]  cfg_data;
  logic [15:0] clk_out;
  logic [15:0] clk_oe;
  logic        fb_out;
  logic [1:0]  dly_sel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 ref_clk = ~ref_clk;

  ckg_fanout u_ckg_fanout (
    .ref_clk(ref_clk), .rst_n(rst_n), .drv_en(drv_en), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .clk_out(clk_out),
    .clk_oe(clk_oe), .fb_out(fb_out), .dly_sel(dly_sel)
  );

  // {idx, data, expected clk_out in high phase, expected dly_sel}
  localparam logic [27:0] VEC [8] = '{
    {2'd1, 8'h00, 16'hFF00, 2'd0},
    {2'd2, 8'h0F, 16'h0F00, 2'd0},
    {2'd1, 8'hA5, 16'h0FA5, 2'd0},
    {2'd0, 8'h03, 16'h0FA5, 2'd3},
    {2'd0, 8'hFE, 16'h0FA5, 2'd2},
    {2'd3, 8'h00, 16'h0FA5, 2'd2},
    {2'd2, 8'h80, 16'h80A5, 2'd2},
    {2'd1, 8'h01, 16'h8001, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_byte(input logic [1:0] i, input logic [7:0] d);
    @(posedge ref_clk); #1;
    cfg_we = 1'b1; cfg_idx = i; cfg_data = d;
    @(posedge ref_clk); #1;
    cfg_we = 1'b0;
    @(posedge ref_clk); #1;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; drv_en = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
    repeat (3) @(posedge ref_clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge ref_clk);
    #1;
    // R6 reset state, clock high phase
    chk("R6 enables", 32'(clk_out), 32'hFFFF);
    chk("R6 oe", 32'(clk_oe), 32'hFFFF);
    chk("R6 dly", 32'(dly_sel), 32'd0);
    chk("R5 fb high", 32'(fb_out), 32'd1);
    #2.5;
    chk("R2 low phase", 32'(clk_out), 32'h0);
    chk("R5 fb low", 32'(fb_out), 32'd0);

    for (int v = 0; v < 8; v++) begin
      write_byte(VEC[v][27:26], VEC[v][25:18]);
      if (VEC[v][27:26] == 2'd3) begin
        chk("R8 idx3 enables", 32'(clk_out), 32'(VEC[v][17:2]));
        chk("R8 idx3 dly", 32'(dly_sel), 32'(VEC[v][1:0]));
      end else begin
        chk("R1 R3 enables", 32'(clk_out), 32'(VEC[v][17:2]));
        chk("R7 dly", 32'(dly_sel), 32'(VEC[v][1:0]));
      end
      #2.5;
      chk("R2 low phase", 32'(clk_out), 32'h0);
    end

    // R3 timing: value must not appear before the falling edge after capture
    @(posedge ref_clk); #1;
    cfg_we = 1'b1; cfg_idx = 2'd1; cfg_data = 8'hFF;
    @(posedge ref_clk); #1;
    cfg_we = 1'b0;
    chk("R3 old value until fall", 32'(clk_out), 32'h8001);
    @(posedge ref_clk); #1;
    chk("R3 new value after fall", 32'(clk_out), 32'h80FF);

    // R4 tri-state with 2-edge latency, R9 independence
    @(posedge ref_clk); #1;
    drv_en = 1'b0;
    @(posedge ref_clk); #1;
    chk("R4 latency hold", 32'(clk_oe), 32'hFFFF);
    @(posedge ref_clk); #1;
    chk("R4 tristate", 32'(clk_oe), 32'h0);
    chk("R9 enables kept", 32'(clk_out), 32'h80FF);
    chk("R5 fb while off", 32'(fb_out), 32'd1);
    write_byte(2'd2, 8'h00);
    chk("R9 oe unaffected by enables", 32'(clk_oe), 32'h0);
    chk("R9 enables with oe low", 32'(clk_out), 32'h00FF);
    #2.5;
    chk("R5 fb low while off", 32'(fb_out), 32'd0);
    @(posedge ref_clk); #1;
    drv_en = 1'b1;
    @(posedge ref_clk); #1;
    @(posedge ref_clk); #1;
    chk("R4 drive restored", 32'(clk_oe), 32'hFFFF);

    // R6 mid-run reset restores defaults
    write_byte(2'd0, 8'h01);
    chk("R7 dly 01", 32'(dly_sel), 32'd1);
    rst_n = 1'b0;
    #0.5;
    chk("R6 async dly", 32'(dly_sel), 32'd0);
    @(posedge ref_clk); #1;
    chk("R6 enables in reset", 32'(clk_out), 32'hFFFF);
    chk("R5 fb in reset", 32'(fb_out), 32'd1);
    rst_n = 1'b1;
    repeat (3) @(posedge ref_clk);
    #1;
    chk("R6 after release", 32'(clk_out), 32'hFFFF);
    chk("R6 oe after release", 32'(clk_oe), 32'hFFFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule